// File: doc/BRIEF.md
# Aspect-Configurable Synchronous Block RAM

A 4-kilobit simple dual-port memory whose physical store is 256 words of 16 bits. A single elaboration-time switch sets how both ports see that store. In word view it is 256 entries of 16 bits, and a per-bit write mask is available. In byte view it is 512 entries of 8 bits. A byte travels on the even-numbered lines of the 16-bit data buses, and each physical word holds two bytes that are interleaved bit by bit.

The read port and the write port each have their own clock, clock enable and port enable, plus an 11-bit address. Reads are registered: the read output changes only on a read clock edge at which both read enables are high. The power-up contents come from sixteen 256-bit preload parameters. Each parameter covers sixteen consecutive physical words, so the preload image has the same layout as the physical array in either view.

Top module: `aspect_ram`

## Requirements
- R1: With BYTE_MODE=1, byte address A (A < 512) is physical word A[7:0]. Its bit i sits at word bit 2i+A[8]. A read puts bit i at rdData[2i] and drives every odd rdData bit to 0.
- R2: A byte-view write changes only the eight word bits of the lane that A[8] selects. The other lane of that word keeps its value.
- R3: In byte view, the write drops the odd bits of wrData and ignores wrMask completely.
- R4: Physical word n = 16k+j starts out as bits [16j+15:16j] of preload parameter PRELOAD_k.
- R5: rdData loads on a rising rdClk only when rdClkEn and rdEn are both 1. Otherwise it holds its value.
- R6: The store changes on a rising wrClk only when wrClkEn and wrEn are both 1.
- R7: With BYTE_MODE=0, word address wrAddr[7:0] is written. A wrMask bit at 1 keeps the matching stored bit. A read returns the full 16-bit word.
- R8: When a read and a write reach the same physical word on one shared clock edge, the read returns the contents from before the write.
- R9: Before the first enabled read, rdData is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rdClk | input | 1 | Read clock |
| rdClkEn | input | 1 | Read clock enable |
| rdEn | input | 1 | Read port enable |
| rdAddr | input | 11 | Read address (bits 7:0 word view, bits 8:0 byte view) |
| rdData | output | 16 | Registered read data |
| wrClk | input | 1 | Write clock |
| wrClkEn | input | 1 | Write clock enable |
| wrEn | input | 1 | Write port enable |
| wrAddr | input | 11 | Write address |
| wrData | input | 16 | Write data (even lines only in byte view) |
| wrMask | input | 16 | Per-bit write block, word view only |

## Verification
A read and a write can land on the same physical word at the same edge. In byte view the write can also hit the opposite lane of the word being read. The bench ties both ports to one clock and issues a read and a write to one address in the same cycle, in both views. It expects the pre-write value on that edge and the new value on a later read. Full sweeps over all 512 byte addresses and all 256 words are compared against an arithmetic shadow of the store, and that shadow applies lane and mask rules taken only from the requirements.

// File: rtl/aspect_ram_pkg.sv
package aspect_ram_pkg;
  localparam int WORD_W  = 16;
  localparam int DEPTH   = 256;
  localparam int IDX_W   = $clog2(DEPTH);
  localparam int ADDR_W  = 11;
  localparam int BYTE_W  = WORD_W / 2;
  localparam int SEG_W   = 256;
  localparam int NUM_SEG = (DEPTH * WORD_W) / SEG_W;

  typedef struct packed {
    logic              wrFire;
    logic [IDX_W-1:0]  wrIdx;
    logic [WORD_W-1:0] wrBitEn;
    logic              rdFire;
    logic [IDX_W-1:0]  rdIdx;
    logic              rdLaneHi;
  } ramStrb_t;
endpackage

// File: rtl/aspect_ram_ctrl.sv
module aspect_ram_ctrl
  import aspect_ram_pkg::*;
#(
  parameter bit BYTE_MODE = 1'b1
) (
  input  logic              rdClkEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wrClkEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrMask,
  output ramStrb_t          strb
);
  logic              wrGo;
  logic [WORD_W-1:0] laneEn;
  logic              unusedSink;

  assign wrGo = wrClkEn & wrEn;

  generate
    if (BYTE_MODE) begin : g_byteLanes
      for (genvar i = 0; i < BYTE_W; i++) begin : g_lane
        assign laneEn[2*i]   = ~wrAddr[IDX_W];
        assign laneEn[2*i+1] =  wrAddr[IDX_W];
      end
      assign unusedSink = ^{rdAddr[ADDR_W-1:IDX_W+1], wrAddr[ADDR_W-1:IDX_W+1], wrMask};
    end else begin : g_wordLanes
      assign laneEn     = ~wrMask;
      assign unusedSink = ^{rdAddr[ADDR_W-1:IDX_W], wrAddr[ADDR_W-1:IDX_W]};
    end
  endgenerate

  always_comb begin
    strb.wrFire   = wrGo;
    strb.wrIdx    = wrAddr[IDX_W-1:0];
    strb.wrBitEn  = wrGo ? laneEn : '0;
    strb.rdFire   = rdClkEn & rdEn;
    strb.rdIdx    = rdAddr[IDX_W-1:0];
    strb.rdLaneHi = BYTE_MODE ? rdAddr[IDX_W] : 1'b0;
  end
endmodule

// File: rtl/aspect_ram_dp.sv
module aspect_ram_dp
  import aspect_ram_pkg::*;
#(
  parameter bit                        BYTE_MODE  = 1'b1,
  parameter logic [DEPTH*WORD_W-1:0]   INIT_IMAGE = '0
) (
  input  logic              rdClk,
  input  logic              wrClk,
  input  ramStrb_t          strb,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData
);
  logic [WORD_W-1:0] memArr [DEPTH];
  logic [WORD_W-1:0] srcData;
  logic [WORD_W-1:0] rdWord = '0;
  logic              rdLane = 1'b0;
  logic              unusedSink;

  initial begin
    for (int n = 0; n < DEPTH; n++) memArr[n] = INIT_IMAGE[n*WORD_W +: WORD_W];
  end

  generate
    if (BYTE_MODE) begin : g_byteData
      for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        assign srcData[2*i]   = wrData[2*i];
        assign srcData[2*i+1] = wrData[2*i];
        assign rdData[2*i]    = rdLane ? rdWord[2*i+1] : rdWord[2*i];
        assign rdData[2*i+1]  = 1'b0;
      end
      assign unusedSink = ^{strb.rdFire, 1'b0};
    end else begin : g_wordData
      assign srcData    = wrData;
      assign rdData     = rdWord;
      assign unusedSink = ^{rdLane, 1'b0};
    end
  endgenerate

  always_ff @(posedge wrClk) begin
    if (strb.wrFire) begin
      for (int b = 0; b < WORD_W; b++) begin
        if (strb.wrBitEn[b]) memArr[strb.wrIdx][b] <= srcData[b];
      end
    end
  end

  always_ff @(posedge rdClk) begin
    if (strb.rdFire) begin
      rdWord <= memArr[strb.rdIdx];
      rdLane <= strb.rdLaneHi;
    end
  end
endmodule

// File: rtl/aspect_ram.sv
module aspect_ram
  import aspect_ram_pkg::*;
#(
  parameter bit           BYTE_MODE = 1'b1,
  parameter logic [255:0] PRELOAD_0 = '0,
  parameter logic [255:0] PRELOAD_1 = '0,
  parameter logic [255:0] PRELOAD_2 = '0,
  parameter logic [255:0] PRELOAD_3 = '0,
  parameter logic [255:0] PRELOAD_4 = '0,
  parameter logic [255:0] PRELOAD_5 = '0,
  parameter logic [255:0] PRELOAD_6 = '0,
  parameter logic [255:0] PRELOAD_7 = '0,
  parameter logic [255:0] PRELOAD_8 = '0,
  parameter logic [255:0] PRELOAD_9 = '0,
  parameter logic [255:0] PRELOAD_A = '0,
  parameter logic [255:0] PRELOAD_B = '0,
  parameter logic [255:0] PRELOAD_C = '0,
  parameter logic [255:0] PRELOAD_D = '0,
  parameter logic [255:0] PRELOAD_E = '0,
  parameter logic [255:0] PRELOAD_F = '0
) (
  input  logic        rdClk,
  input  logic        rdClkEn,
  input  logic        rdEn,
  input  logic [10:0] rdAddr,
  output logic [15:0] rdData,
  input  logic        wrClk,
  input  logic        wrClkEn,
  input  logic        wrEn,
  input  logic [10:0] wrAddr,
  input  logic [15:0] wrData,
  input  logic [15:0] wrMask
);
  localparam logic [DEPTH*WORD_W-1:0] IMAGE = {
    PRELOAD_F, PRELOAD_E, PRELOAD_D, PRELOAD_C, PRELOAD_B, PRELOAD_A, PRELOAD_9, PRELOAD_8,
    PRELOAD_7, PRELOAD_6, PRELOAD_5, PRELOAD_4, PRELOAD_3, PRELOAD_2, PRELOAD_1, PRELOAD_0};

  ramStrb_t ctrlStrb;

  aspect_ram_ctrl #(.BYTE_MODE(BYTE_MODE)) u_ctrl (
    .rdClkEn(rdClkEn), .rdEn(rdEn), .rdAddr(rdAddr),
    .wrClkEn(wrClkEn), .wrEn(wrEn), .wrAddr(wrAddr), .wrMask(wrMask),
    .strb(ctrlStrb)
  );

  aspect_ram_dp #(.BYTE_MODE(BYTE_MODE), .INIT_IMAGE(IMAGE)) u_dp (
    .rdClk(rdClk), .wrClk(wrClk), .strb(ctrlStrb),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/aspect_ram_chk.sv
module aspect_ram_chk
  import aspect_ram_pkg::*;
#(
  parameter bit BYTE_MODE = 1'b1
) (
  input logic              rdClk,
  input logic              wrClk,
  input logic              rdClkEn,
  input logic              rdEn,
  input logic [WORD_W-1:0] rdData,
  input logic              wrClkEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [WORD_W-1:0] wrMask,
  input ramStrb_t          strb
);
  logic armedRd = 1'b0;
  logic armedWr = 1'b0;
  always_ff @(posedge rdClk) armedRd <= 1'b1;
  always_ff @(posedge wrClk) armedWr <= 1'b1;

  AST_RD_HOLD: assert property (@(posedge rdClk) disable iff (!armedRd)
    !(rdClkEn && rdEn) |=> $stable(rdData)); // R5

  AST_IDLE_NO_WRITE: assert property (@(posedge wrClk) disable iff (!armedWr)
    !(wrClkEn && wrEn) |-> (strb.wrBitEn == '0)); // R6

  generate
    if (BYTE_MODE) begin : g_byteChk
      AST_ODD_READ_ZERO: assert property (@(posedge rdClk) disable iff (!armedRd)
        (rdData & 16'hAAAA) == '0); // R1

      AST_LANE_COUNT: assert property (@(posedge wrClk) disable iff (!armedWr)
        (wrClkEn && wrEn) |-> ($countones(strb.wrBitEn) == BYTE_W)); // R3

      AST_LANE_SIDE: assert property (@(posedge wrClk) disable iff (!armedWr)
        (wrClkEn && wrEn) |->
          ((strb.wrBitEn & (wrAddr[IDX_W] ? 16'h5555 : 16'hAAAA)) == '0)); // R2
    end else begin : g_wordChk
      AST_MASK_KEEPS: assert property (@(posedge wrClk) disable iff (!armedWr)
        (wrClkEn && wrEn) |-> ((strb.wrBitEn & wrMask) == '0)); // R7
    end
  endgenerate
endmodule

bind aspect_ram aspect_ram_chk #(.BYTE_MODE(BYTE_MODE)) u_chk (
  .rdClk(rdClk), .wrClk(wrClk), .rdClkEn(rdClkEn), .rdEn(rdEn), .rdData(rdData),
  .wrClkEn(wrClkEn), .wrEn(wrEn), .wrAddr(wrAddr), .wrMask(wrMask), .strb(ctrlStrb)
);

// File: tb/aspect_ram_bench.sv
`timescale 1ns/1ps
module aspect_ram_bench;
  localparam real CLK_NS = 20.0;

  function automatic logic [15:0] initWord(input int n);
    return 16'((n * 40503 + 4660) & 16'hFFFF);
  endfunction

  function automatic logic [255:0] segVal(input int k);
    logic [255:0] r;
    r = '0;
    for (int j = 0; j < 16; j++) r[16*j +: 16] = initWord(16*k + j);
    return r;
  endfunction

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic        bRce = 0, bRe = 0, bWce = 0, bWe = 0;
  logic [10:0] bRa = '0, bWa = '0;
  logic [15:0] bWd = '0, bWm = '0, bRd;
  logic        wRce = 0, wRe = 0, wWce = 0, wWe = 0;
  logic [10:0] wRa = '0, wWa = '0;
  logic [15:0] wWd = '0, wWm = '0, wRd;

  aspect_ram #(.BYTE_MODE(1'b1),
    .PRELOAD_0(segVal(0)), .PRELOAD_1(segVal(1)), .PRELOAD_2(segVal(2)), .PRELOAD_3(segVal(3)),
    .PRELOAD_4(segVal(4)), .PRELOAD_5(segVal(5)), .PRELOAD_6(segVal(6)), .PRELOAD_7(segVal(7)),
    .PRELOAD_8(segVal(8)), .PRELOAD_9(segVal(9)), .PRELOAD_A(segVal(10)), .PRELOAD_B(segVal(11)),
    .PRELOAD_C(segVal(12)), .PRELOAD_D(segVal(13)), .PRELOAD_E(segVal(14)), .PRELOAD_F(segVal(15))
  ) u_aspect_ram (
    .rdClk(clk), .rdClkEn(bRce), .rdEn(bRe), .rdAddr(bRa), .rdData(bRd),
    .wrClk(clk), .wrClkEn(bWce), .wrEn(bWe), .wrAddr(bWa), .wrData(bWd), .wrMask(bWm));

  aspect_ram #(.BYTE_MODE(1'b0),
    .PRELOAD_0(segVal(0)), .PRELOAD_1(segVal(1)), .PRELOAD_2(segVal(2)), .PRELOAD_3(segVal(3)),
    .PRELOAD_4(segVal(4)), .PRELOAD_5(segVal(5)), .PRELOAD_6(segVal(6)), .PRELOAD_7(segVal(7)),
    .PRELOAD_8(segVal(8)), .PRELOAD_9(segVal(9)), .PRELOAD_A(segVal(10)), .PRELOAD_B(segVal(11)),
    .PRELOAD_C(segVal(12)), .PRELOAD_D(segVal(13)), .PRELOAD_E(segVal(14)), .PRELOAD_F(segVal(15))
  ) u_aspect_ram_word (
    .rdClk(clk), .rdClkEn(wRce), .rdEn(wRe), .rdAddr(wRa), .rdData(wRd),
    .wrClk(clk), .wrClkEn(wWce), .wrEn(wWe), .wrAddr(wWa), .wrData(wWd), .wrMask(wWm));

  logic [15:0] bModel [256];
  logic [15:0] wModel [256];
  logic [15:0] bHeld = '0, wHeld = '0;
  int runCnt = 0, failCnt = 0;

  function automatic logic [15:0] spreadByte(input logic [15:0] word, input logic hi);
    logic [15:0] r;
    r = '0;
    for (int i = 0; i < 8; i++) r[2*i] = word[2*i + int'(hi)];
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    runCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock of traffic on the byte-view instance; enables drop afterwards.
  task automatic opB(input logic rce, re, input logic [10:0] ra,
                     input logic wce, we, input logic [10:0] wa,
                     input logic [15:0] wd, wm);
    @(negedge clk);
    bRce = rce; bRe = re; bRa = ra; bWce = wce; bWe = we; bWa = wa; bWd = wd; bWm = wm;
    if (rce && re) bHeld = spreadByte(bModel[ra[7:0]], ra[8]);
    @(posedge clk);
    if (wce && we)
      for (int i = 0; i < 8; i++) bModel[wa[7:0]][2*i + int'(wa[8])] = wd[2*i];
    @(negedge clk);
    bRce = 0; bRe = 0; bWce = 0; bWe = 0;
  endtask

  task automatic opW(input logic rce, re, input logic [10:0] ra,
                     input logic wce, we, input logic [10:0] wa,
                     input logic [15:0] wd, wm);
    @(negedge clk);
    wRce = rce; wRe = re; wRa = ra; wWce = wce; wWe = we; wWa = wa; wWd = wd; wWm = wm;
    if (rce && re) wHeld = wModel[ra[7:0]];
    @(posedge clk);
    if (wce && we)
      for (int b = 0; b < 16; b++) if (!wm[b]) wModel[wa[7:0]][b] = wd[b];
    @(negedge clk);
    wRce = 0; wRe = 0; wWce = 0; wWe = 0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin
    for (int n = 0; n < 256; n++) begin bModel[n] = initWord(n); wModel[n] = initWord(n); end
    repeat (3) @(negedge clk);
    chk("R9 byte view power-up", bRd, 16'h0000);
    chk("R9 word view power-up", wRd, 16'h0000);

    // R1 / R4: read every preloaded byte and word
    for (int a = 0; a < 512; a++) begin
      opB(1, 1, 11'(a), 0, 0, '0, '0, '0);
      chk("R1 R4 byte preload read", bRd, bHeld);
    end
    for (int a = 0; a < 256; a++) begin
      opW(1, 1, 11'(a), 0, 0, '0, '0, '0);
      chk("R4 R7 word preload read", wRd, wHeld);
    end
    opB(1, 1, 11'd272, 0, 0, '0, '0, '0);
    chk("R4 second segment low word, high lane", bRd, spreadByte(segVal(1)[15:0], 1'b1));

    // R2 / R3: write low lane of every word with odd garbage and full mask
    for (int a = 0; a < 256; a++)
      opB(0, 0, '0, 1, 1, 11'(a), 16'(a * 97 + 13) | 16'hAAAA, 16'hFFFF);
    for (int a = 0; a < 512; a++) begin
      opB(1, 1, 11'(a), 0, 0, '0, '0, '0);
      chk("R2 R3 low lane written, high lane kept", bRd, bHeld);
    end
    for (int a = 256; a < 512; a++)
      opB(0, 0, '0, 1, 1, 11'(a), 16'(a * 53 + 7) & 16'h5555 | 16'(a << 1), 16'h0F0F);
    for (int a = 0; a < 512; a++) begin
      opB(1, 1, 11'(a), 0, 0, '0, '0, '0);
      chk("R2 R3 high lane written", bRd, bHeld);
    end

    // R5: read enables off leave rdData alone
    opB(1, 1, 11'd5, 0, 0, '0, '0, '0);
    opB(0, 1, 11'd300, 0, 0, '0, '0, '0);
    chk("R5 rdClkEn low holds byte read", bRd, spreadByte(bModel[5], 1'b0));
    opB(1, 0, 11'd300, 0, 0, '0, '0, '0);
    chk("R5 rdEn low holds byte read", bRd, spreadByte(bModel[5], 1'b0));
    opW(1, 1, 11'd9, 0, 0, '0, '0, '0);
    opW(1, 0, 11'd200, 0, 0, '0, '0, '0);
    chk("R5 rdEn low holds word read", wRd, wModel[9]);

    // R6: write enables off leave the store alone
    opB(0, 0, '0, 0, 1, 11'd40, 16'h5555, '0);
    opB(0, 0, '0, 1, 0, 11'd40, 16'h5555, '0);
    opB(1, 1, 11'd40, 0, 0, '0, '0, '0);
    chk("R6 byte write blocked", bRd, bHeld);
    opW(0, 0, '0, 0, 1, 11'd41, 16'hFFFF, '0);
    opW(0, 0, '0, 1, 0, 11'd41, 16'hFFFF, '0);
    opW(1, 1, 11'd41, 0, 0, '0, '0, '0);
    chk("R6 word write blocked", wRd, wModel[41]);

    // R7: word view with masks
    for (int a = 0; a < 256; a++)
      opW(0, 0, '0, 1, 1, 11'(a), 16'(a * 4099 + 77), 16'(a * 257 ^ 16'h3C3C));
    for (int a = 0; a < 256; a++) begin
      opW(1, 1, 11'(a), 0, 0, '0, '0, '0);
      chk("R7 masked word write", wRd, wHeld);
    end

    // R8: same word, same edge
    begin
      logic [15:0] oldW;
      oldW = wModel[77];
      opW(1, 1, 11'd77, 1, 1, 11'd77, 16'hBEEF, 16'h0000);
      chk("R8 word collision returns old", wRd, oldW);
      opW(1, 1, 11'd77, 0, 0, '0, '0, '0);
      chk("R8 word collision new value", wRd, 16'hBEEF);
    end
    begin
      logic [15:0] oldB;
      oldB = spreadByte(bModel[44], 1'b1);
      opB(1, 1, 11'd300, 1, 1, 11'd300, 16'h0055, '0);
      chk("R8 byte collision returns old", bRd, oldB);
      opB(1, 1, 11'd300, 0, 0, '0, '0, '0);
      chk("R8 byte collision new value", bRd, 16'h0055);
      opB(1, 1, 11'd44, 1, 1, 11'd300, 16'h1111, '0);
      chk("R8 R2 opposite lane same edge", bRd, spreadByte(bModel[44], 1'b0));
    end

    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule